// File: doc/BRIEF.md
# Write-Side Burst Issue Controller

This block drives the write address and write data channels of an AXI-style memory port on behalf of a DMA engine. Upstream logic hands it two independent streams: write descriptors (start address, beat count, fixed or incrementing address mode) and the data beats that fill those writes. The controller queues both. It raises a write address only when every beat of that transfer is already held in its internal buffer. This way, once a burst is announced, the data channel never has to wait on the source.

Up to eight address handshakes may be outstanding, meaning they have no write response yet. Data beats leave in descriptor order, one complete burst at a time, with the last-beat marker on the final beat of each burst. Responses retire transfers. A response other than OKAY sets an error flag that stays set until reset.

Top module: `wr_issue_ctrl`

## Requirements
- R1: At most MAX_OUTST (default 8) write addresses are outstanding. While that many have been accepted without a response, awvalid stays low.
- R2: awvalid is not raised for a descriptor until its full payload of awlen+1 beats has been accepted into the buffer.
- R3: Data beats leave in the order they were accepted. All beats of one burst go out before any beat of the next, and a burst's first beat follows the handshake of its own address.
- R4: wlast is high on exactly the (awlen+1)-th beat of each burst and low on every other beat.
- R5: awaddr and awlen equal the descriptor's address and length field. awburst is 2'b00 for a fixed-address descriptor and 2'b01 for an incrementing one. awsize is log2 of the data bus bytes (3'd2 for a 32-bit bus).
- R6: The outstanding count rises on an address handshake and falls on a response handshake, and is unchanged when both occur in one cycle. bready is high exactly while the count is non-zero, so it returns low once every transfer is retired.
- R7: A response with bresp not equal to 2'b00 sets err_flag. Only reset clears it, and later OKAY responses leave it set.
- R8: While awvalid or wvalid is high and its ready is low, the channel's valid and payload hold their values.
- R9: After reset, awvalid, wvalid, bready and err_flag are low, and desc_ready and dat_ready are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Descriptor queue has room |
| desc_addr | input | ADDR_W | Burst start address |
| desc_len | input | LEN_W | Beats minus one |
| desc_fixed | input | 1 | 1 = fixed address, 0 = incrementing |
| dat_valid | input | 1 | Data beat offered |
| dat_ready | output | 1 | Data buffer has room |
| dat_data | input | DATA_W | Beat payload |
| dat_strb | input | DATA_W/8 | Byte enables for the beat |
| awvalid | output | 1 | Write address valid |
| awready | input | 1 | Write address accepted |
| awaddr | output | ADDR_W | Write address |
| awlen | output | LEN_W | Beats minus one |
| awsize | output | 3 | Log2 of bytes per beat |
| awburst | output | 2 | Burst mode |
| wvalid | output | 1 | Write data valid |
| wready | input | 1 | Write data accepted |
| wdata | output | DATA_W | Write data |
| wstrb | output | DATA_W/8 | Write byte enables |
| wlast | output | 1 | Final beat of burst |
| bvalid | input | 1 | Write response valid |
| bready | output | 1 | Response accepted |
| bresp | input | 2 | Response code |
| err_flag | output | 1 | Sticky error-response flag |

## Verification
The bench uses the default parameters: a 32-bit bus, a 64-beat buffer, a four-entry descriptor queue and an eight-deep outstanding limit. With a four-entry queue, ten single-beat descriptors under held responses fill the outstanding limit and still leave the last two parked in the queue, so the cap at eight is reached and observed. The 64-beat buffer holds the longest table burst (16 beats) together with several later bursts. The table also mixes throttled ready signals, so beats and addresses stall and overlap with responses in the same cycle.

// File: rtl/wic_pkg.sv
package wic_pkg;
  localparam logic [1:0] BURST_FIXED = 2'b00;
  localparam logic [1:0] BURST_INCR  = 2'b01;
  localparam logic [1:0] RESP_OKAY   = 2'b00;
endpackage

// File: rtl/wic_fifo.sv
module wic_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int PW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [PW:0]   cnt;

  always_ff @(posedge clk) begin
    if (push && !full) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push && !full) wp <= wp + 1'b1;
      if (pop && !empty) rp <= rp + 1'b1;
      case ({push && !full, pop && !empty})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign dout  = mem[rp];
  assign full  = (cnt == (PW+1)'(DEPTH));
  assign empty = (cnt == '0);

  a_r3_fifo_no_overrun: assert property (@(posedge clk) disable iff (rst)
    full |=> !(cnt == '0));
endmodule

// File: rtl/wic_databuf.sv
module wic_databuf #(
  parameter int W     = 36,
  parameter int DEPTH = 64
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [W-1:0]               wr_data,
  input  logic                       rd_en,
  output logic [W-1:0]               rd_data,
  output logic                       full,
  output logic [$clog2(DEPTH):0]     count
);
  localparam int PW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wr_data;
    if (rd_en) rd_data <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (wr_en) wp <= wp + 1'b1;
      if (rd_en) rp <= rp + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign full = (count == (PW+1)'(DEPTH));

  a_r3_buf_no_underrun: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> count != '0);
endmodule

// File: rtl/wic_wsend.sv
module wic_wsend #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             len_avail,
  input  logic [LEN_W-1:0] len_head,
  output logic             len_pop,
  output logic             buf_rd,
  input  logic             wready,
  output logic             wvalid,
  output logic             wlast
);
  logic             in_burst;
  logic [LEN_W-1:0] cnt, cur_len;
  logic             load;

  assign load    = (in_burst || len_avail) && (!wvalid || wready);
  assign len_pop = load && !in_burst;
  assign buf_rd  = load;

  always_ff @(posedge clk) begin
    if (rst) begin
      wvalid   <= 1'b0;
      wlast    <= 1'b0;
      in_burst <= 1'b0;
      cnt      <= '0;
      cur_len  <= '0;
    end else if (load) begin
      wvalid <= 1'b1;
      if (in_burst) begin
        wlast <= (cnt == cur_len);
        cnt   <= cnt + 1'b1;
        if (cnt == cur_len) in_burst <= 1'b0;
      end else begin
        wlast    <= (len_head == '0);
        cnt      <= LEN_W'(1);
        cur_len  <= len_head;
        in_burst <= (len_head != '0);
      end
    end else if (wready) begin
      wvalid <= 1'b0;
    end
  end

  a_r8_w_hold: assert property (@(posedge clk) disable iff (rst)
    wvalid && !wready |=> wvalid && $stable(wlast));
  a_r4_last_ends_burst: assert property (@(posedge clk) disable iff (rst)
    wvalid && wlast |-> !in_burst);
endmodule

// File: rtl/wr_issue_ctrl.sv
module wr_issue_ctrl
  import wic_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LEN_W      = 8,
  parameter int BUF_DEPTH  = 64,
  parameter int DESC_DEPTH = 4,
  parameter int MAX_OUTST  = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  desc_valid,
  output logic                  desc_ready,
  input  logic [ADDR_W-1:0]     desc_addr,
  input  logic [LEN_W-1:0]      desc_len,
  input  logic                  desc_fixed,
  input  logic                  dat_valid,
  output logic                  dat_ready,
  input  logic [DATA_W-1:0]     dat_data,
  input  logic [DATA_W/8-1:0]   dat_strb,
  output logic                  awvalid,
  input  logic                  awready,
  output logic [ADDR_W-1:0]     awaddr,
  output logic [LEN_W-1:0]      awlen,
  output logic [2:0]            awsize,
  output logic [1:0]            awburst,
  output logic                  wvalid,
  input  logic                  wready,
  output logic [DATA_W-1:0]     wdata,
  output logic [DATA_W/8-1:0]   wstrb,
  output logic                  wlast,
  input  logic                  bvalid,
  output logic                  bready,
  input  logic [1:0]            bresp,
  output logic                  err_flag
);
  localparam int STRB_W   = DATA_W / 8;
  localparam int SIZE_ENC = $clog2(STRB_W);
  localparam int CW       = $clog2(BUF_DEPTH);
  localparam int AVW      = CW + 1;
  localparam int OW       = $clog2(MAX_OUTST + 1);
  localparam int DQ_W     = ADDR_W + LEN_W + 1;
  localparam int BUF_W    = DATA_W + STRB_W;

  // descriptor queue
  logic [DQ_W-1:0]   dq_head;
  logic              dq_full, dq_empty, aw_load;
  logic [ADDR_W-1:0] hd_addr;
  logic [LEN_W-1:0]  hd_len;
  logic              hd_fixed;

  wic_fifo #(.W(DQ_W), .DEPTH(DESC_DEPTH)) u_descq (
    .clk(clk), .rst(rst),
    .push(desc_valid), .din({desc_addr, desc_len, desc_fixed}),
    .pop(aw_load), .dout(dq_head), .full(dq_full), .empty(dq_empty)
  );
  assign {hd_addr, hd_len, hd_fixed} = dq_head;
  assign desc_ready = !dq_full;

  // data buffer
  logic             dat_hs, buf_rd, buf_full;
  logic [BUF_W-1:0] buf_q;
  logic [CW:0]      buf_count;

  assign dat_hs    = dat_valid && !buf_full;
  assign dat_ready = !buf_full;

  wic_databuf #(.W(BUF_W), .DEPTH(BUF_DEPTH)) u_buf (
    .clk(clk), .rst(rst),
    .wr_en(dat_hs), .wr_data({dat_data, dat_strb}),
    .rd_en(buf_rd), .rd_data(buf_q), .full(buf_full), .count(buf_count)
  );
  assign {wdata, wstrb} = buf_q;

  // unclaimed beats: accepted but not yet reserved by a raised address
  logic [AVW-1:0] avail, avail_n;
  logic [OW-1:0]  outst;
  logic           aw_hs, b_hs, payload_ok;

  assign payload_ok = (32'(avail) >= 32'(hd_len) + 32'd1);
  assign aw_load    = !dq_empty && !awvalid && (32'(outst) < MAX_OUTST) && payload_ok;
  assign aw_hs      = awvalid && awready;
  assign b_hs       = bvalid && bready;

  always_comb begin
    avail_n = avail;
    if (dat_hs)  avail_n = avail_n + 1'b1;
    if (aw_load) avail_n = avail_n - AVW'(32'(hd_len) + 32'd1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      avail    <= '0;
      outst    <= '0;
      awvalid  <= 1'b0;
      awaddr   <= '0;
      awlen    <= '0;
      awburst  <= BURST_INCR;
      err_flag <= 1'b0;
    end else begin
      avail <= avail_n;
      if (aw_load) begin
        awvalid <= 1'b1;
        awaddr  <= hd_addr;
        awlen   <= hd_len;
        awburst <= hd_fixed ? BURST_FIXED : BURST_INCR;
      end else if (aw_hs) begin
        awvalid <= 1'b0;
      end
      case ({aw_hs, b_hs})
        2'b10:   outst <= outst + 1'b1;
        2'b01:   outst <= outst - 1'b1;
        default: outst <= outst;
      endcase
      if (b_hs && bresp != RESP_OKAY) err_flag <= 1'b1;
    end
  end

  assign awsize = 3'(SIZE_ENC);
  assign bready = (outst != '0);

  // burst lengths of accepted addresses, in order, for the data sequencer
  logic [LEN_W-1:0] wq_head;
  logic             wq_full, wq_empty, wq_pop;

  wic_fifo #(.W(LEN_W), .DEPTH(MAX_OUTST)) u_lenq (
    .clk(clk), .rst(rst),
    .push(aw_hs), .din(awlen),
    .pop(wq_pop), .dout(wq_head), .full(wq_full), .empty(wq_empty)
  );

  wic_wsend #(.LEN_W(LEN_W)) u_wsend (
    .clk(clk), .rst(rst),
    .len_avail(!wq_empty), .len_head(wq_head), .len_pop(wq_pop),
    .buf_rd(buf_rd), .wready(wready), .wvalid(wvalid), .wlast(wlast)
  );

  a_r1_cap_hold: assert property (@(posedge clk) disable iff (rst)
    awvalid |-> 32'(outst) < MAX_OUTST);
  a_r1_lenq_room: assert property (@(posedge clk) disable iff (rst)
    aw_hs |-> !wq_full);
  a_r2_payload_held: assert property (@(posedge clk) disable iff (rst)
    awvalid |-> 32'(buf_count) >= 32'(awlen) + 32'd1);
  a_r3_w_after_aw: assert property (@(posedge clk) disable iff (rst)
    wvalid |-> outst != '0);
  a_r6_both_hold: assert property (@(posedge clk) disable iff (rst)
    aw_hs && b_hs |=> $stable(outst));
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag);
  a_r8_aw_hold: assert property (@(posedge clk) disable iff (rst)
    awvalid && !awready |=> awvalid && $stable(awaddr) && $stable(awlen) && $stable(awburst));
  a_r8_wdata_hold: assert property (@(posedge clk) disable iff (rst)
    wvalid && !wready |=> $stable(wdata) && $stable(wstrb));
endmodule

// File: tb/tb_wr_issue_ctrl.sv
module tb_wr_issue_ctrl;
  typedef struct packed {
    logic [31:0] addr;
    logic [7:0]  len;
    logic        fixed;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t TBL [NV] = '{
    '{32'h0000_1000, 8'd0,  1'b0},
    '{32'h0000_2000, 8'd3,  1'b0},
    '{32'h0000_3000, 8'd15, 1'b0},
    '{32'h0000_4004, 8'd1,  1'b1},
    '{32'h0000_5000, 8'd7,  1'b0},
    '{32'h0000_6008, 8'd0,  1'b1},
    '{32'h0000_7000, 8'd5,  1'b1},
    '{32'h0000_8000, 8'd2,  1'b0},
    '{32'h0000_9000, 8'd0,  1'b0},
    '{32'h0000_A000, 8'd9,  1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        desc_valid = 0, desc_fixed = 0;
  logic [31:0] desc_addr = 0;
  logic [7:0]  desc_len = 0;
  logic        dat_valid = 0;
  logic [31:0] dat_data = 0;
  logic [3:0]  dat_strb = 0;
  logic        desc_ready, dat_ready;
  logic        awvalid, wvalid, wlast, bready, err_flag;
  logic [31:0] awaddr, wdata;
  logic [7:0]  awlen;
  logic [2:0]  awsize;
  logic [1:0]  awburst;
  logic [3:0]  wstrb;
  logic        awready_s = 0, wready_s = 0, bvalid_s = 0;
  logic [1:0]  bresp_s = 0;

  wr_issue_ctrl dut (
    .clk(clk), .rst(rst),
    .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_addr(desc_addr),
    .desc_len(desc_len), .desc_fixed(desc_fixed),
    .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_data(dat_data), .dat_strb(dat_strb),
    .awvalid(awvalid), .awready(awready_s), .awaddr(awaddr), .awlen(awlen),
    .awsize(awsize), .awburst(awburst),
    .wvalid(wvalid), .wready(wready_s), .wdata(wdata), .wstrb(wstrb), .wlast(wlast),
    .bvalid(bvalid_s), .bready(bready), .bresp(bresp_s), .err_flag(err_flag)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expectations
  logic [31:0] exp_addr [256];
  logic [7:0]  exp_len  [256];
  logic        exp_fix  [256];
  bit          exp_last [512];
  int desc_n = 0, beat_plan = 0, data_n = 0;
  int aw_n = 0, w_n = 0, w_txn = 0, b_n = 0, outst_m = 0, max_o = 0;

  // slave controls
  bit throttle = 0, b_hold = 0;
  logic [1:0] bresp_next = 2'b00;
  int bpend = 0, cyc = 0;

  always @(posedge clk) begin
    if (rst) begin
      bpend = 0; cyc = 0;
      bvalid_s <= 0; wready_s <= 0; awready_s <= 0; bresp_s <= 0;
    end else begin
      cyc++;
      if (wvalid && wready_s && wlast) bpend++;
      if (bvalid_s && bready) bpend--;
      bvalid_s  <= !b_hold && (bpend > 0);
      bresp_s   <= bresp_next;
      wready_s  <= !throttle || cyc[0];
      awready_s <= !throttle || cyc[1];
    end
  end

  // monitor, sampled mid-cycle
  bit aw_st = 0, w_st = 0;
  logic [31:0] sv_awaddr, sv_wdata;
  logic [7:0]  sv_awlen;
  logic        sv_wlast;

  always @(negedge clk) begin
    if (rst) begin
      aw_st = 0; w_st = 0;
    end else begin
      if (aw_st) chk(awvalid && awaddr == sv_awaddr && awlen == sv_awlen, "R8 aw hold",
                     {awvalid, awaddr, awlen}, {1'b1, sv_awaddr, sv_awlen});
      if (w_st) chk(wvalid && wdata == sv_wdata && wlast == sv_wlast, "R8 w hold",
                    {wvalid, wdata, wlast}, {1'b1, sv_wdata, sv_wlast});
      aw_st = awvalid && !awready_s;
      w_st  = wvalid && !wready_s;
      sv_awaddr = awaddr; sv_awlen = awlen; sv_wdata = wdata; sv_wlast = wlast;

      if (wvalid && wready_s) begin
        chk(w_txn < aw_n, "R3 beat before its address", 64'(w_txn), 64'(aw_n));
        chk(wdata == 32'hC0DE_0000 + 32'(w_n) && wstrb == (4'(w_n) | 4'h1), "R3 data order",
            {wdata, wstrb}, {32'hC0DE_0000 + 32'(w_n), 4'(w_n) | 4'h1});
        chk(wlast == exp_last[w_n], "R4 wlast", 64'(wlast), 64'(exp_last[w_n]));
        if (wlast) w_txn++;
        w_n++;
      end
      if (awvalid && awready_s) begin
        chk(awaddr == exp_addr[aw_n] && awlen == exp_len[aw_n] &&
            awburst == (exp_fix[aw_n] ? 2'b00 : 2'b01) && awsize == 3'd2, "R5 address fields",
            {awaddr, awlen, awburst, awsize},
            {exp_addr[aw_n], exp_len[aw_n], (exp_fix[aw_n] ? 2'b00 : 2'b01), 3'd2});
        aw_n++; outst_m++;
        if (outst_m > max_o) max_o = outst_m;
      end
      if (bvalid_s && bready) begin
        b_n++; outst_m--;
      end
    end
  end

  task automatic push_desc(input logic [31:0] a, input logic [7:0] l, input logic f);
    exp_addr[desc_n] = a; exp_len[desc_n] = l; exp_fix[desc_n] = f;
    exp_last[beat_plan + int'(l)] = 1'b1;
    beat_plan += int'(l) + 1;
    desc_n++;
    @(posedge clk); #1;
    desc_valid = 1; desc_addr = a; desc_len = l; desc_fixed = f;
    @(negedge clk);
    while (!desc_ready) @(negedge clk);
    @(posedge clk); #1;
    desc_valid = 0;
  endtask

  task automatic push_data(input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      dat_valid = 1; dat_data = 32'hC0DE_0000 + 32'(data_n); dat_strb = 4'(data_n) | 4'h1;
      @(negedge clk);
      while (!dat_ready) @(negedge clk);
      @(posedge clk); #1;
      dat_valid = 0;
      data_n++;
      if (gaps && (i % 3 == 2)) @(posedge clk);
    end
  endtask

  task automatic wait_done();
    while (b_n != desc_n || w_n != beat_plan) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", b_n, desc_n);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int tbl_beats, start;
    repeat (5) @(posedge clk); #1;
    rst = 0;
    @(negedge clk);
    chk(!awvalid && !wvalid && !bready && !err_flag && desc_ready && dat_ready, "R9 reset state",
        {awvalid, wvalid, bready, err_flag, desc_ready, dat_ready}, 6'b000011);

    // table walk with throttled slave
    throttle = 1;
    tbl_beats = 0;
    for (int v = 0; v < NV; v++) tbl_beats += int'(TBL[v].len) + 1;
    fork
      for (int v = 0; v < NV; v++) push_desc(TBL[v].addr, TBL[v].len, TBL[v].fixed);
      push_data(tbl_beats, 1'b1);
    join
    wait_done();
    chk(max_o <= 8, "R1 table cap", 64'(max_o), 64'd8);
    chk(!err_flag, "R7 no error on OKAY", 64'(err_flag), 64'd0);
    chk(!bready && outst_m == 0, "R6 count back to zero", {bready, 32'(outst_m)}, 64'd0);

    // payload gating
    throttle = 0;
    start = aw_n;
    push_desc(32'h0001_0000, 8'd3, 1'b0);
    push_data(3, 1'b0);
    repeat (8) @(negedge clk);
    chk(!awvalid && aw_n == start, "R2 held with 3 of 4 beats", {awvalid, 32'(aw_n)}, {1'b0, 32'(start)});
    push_data(1, 1'b0);
    repeat (4) @(negedge clk);
    chk(aw_n == start + 1, "R2 issued once complete", 64'(aw_n), 64'(start + 1));
    wait_done();

    // outstanding cap with responses held
    b_hold = 1;
    fork
      for (int v = 0; v < 10; v++) push_desc(32'h0002_0000 + 32'(v * 4), 8'd0, 1'b0);
      push_data(10, 1'b0);
    join
    repeat (40) @(negedge clk);
    chk(outst_m == 8, "R1 cap reached", 64'(outst_m), 64'd8);
    chk(!awvalid, "R1 no address at cap", 64'(awvalid), 64'd0);
    b_hold = 0;
    wait_done();
    chk(max_o == 8, "R1 never above cap", 64'(max_o), 64'd8);
    chk(!bready && outst_m == 0, "R6 drained after cap", {bready, 32'(outst_m)}, 64'd0);

    // sticky error
    bresp_next = 2'b10;
    fork
      push_desc(32'h0003_0000, 8'd1, 1'b1);
      push_data(2, 1'b0);
    join
    wait_done();
    bresp_next = 2'b00;
    chk(err_flag, "R7 set on error response", 64'(err_flag), 64'd1);
    fork
      push_desc(32'h0003_1000, 8'd0, 1'b0);
      push_data(1, 1'b0);
    join
    wait_done();
    chk(err_flag, "R7 stays set after OKAY", 64'(err_flag), 64'd1);

    // reset clears
    @(posedge clk); #1 rst = 1;
    repeat (2) @(posedge clk); #1 rst = 0;
    @(negedge clk);
    chk(!err_flag && !awvalid && !wvalid && !bready, "R9 reset clears",
        {err_flag, awvalid, wvalid, bready}, 4'b0000);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule